// File: doc/BRIEF.md
# Tagged Bitstream Header Parser

This block reads a configuration container one byte at a time and walks its tagged header. The container opens with a preamble: a 16-bit length followed by that many bytes. A second 16-bit word comes next. After that come single-byte tags. The block drops the preamble and ignores the second word. It passes the characters of each text field to a capture port, tagged with a field code. When it reaches the data tag, it reads a 32-bit payload length and then streams exactly that many payload bytes to a downstream port with backpressure.

The input uses a valid/ready handshake plus an end-of-input marker. The payload port is a direct pass-through: it costs no cycle, and a stall downstream holds the input. Text characters leave one cycle after they are accepted, on a strobe with no backpressure. The block stops taking input once it finishes or fails. It raises one of two sticky error flags: one for a tag it does not know, one for input that ends before a declared length is used up. Reset returns it to the start of a new container.

Top module: `bitfile_hdr_walker`

## Requirements
- R1: After reset, in_ready is 1 and done, err_unknown_tag, err_truncated, pay_len_valid, str_valid and pay_valid are all 0.
- R2: The first two bytes form a big-endian (high byte first) preamble length N. The next N bytes are consumed and cause no activity on any output. N may be 0.
- R3: The two bytes after the preamble are consumed and their value has no effect on any output.
- R4: Tag bytes 0x61..0x64 ('a'..'d') are text fields with field codes 0..3. Each tag is followed by a big-endian 16-bit length and that many characters. Each character is presented on str_byte with str_field, one cycle after it is accepted, for exactly one cycle of str_valid. str_last is 1 only on the field's final character. A zero-length field produces no strobe. Text fields may appear in any order.
- R5: Tag byte 0x65 ('e') is followed by a big-endian 32-bit length. It appears on pay_len, with pay_len_valid set, from the cycle after its last byte is accepted until reset.
- R6: Exactly pay_len payload bytes are forwarded in order. In that phase pay_valid equals in_valid, pay_data equals in_data and in_ready equals pay_ready, all in the same cycle.
- R7: done rises in the cycle after the last payload byte is accepted, or after the last length byte if the length is 0. From then on in_ready is 0.
- R8: Any other tag byte sets err_unknown_tag in the following cycle and stops input (in_ready 0). This takes precedence over a truncation on the same byte.
- R9: If a byte accepted with in_last=1 is not the container's final byte, err_truncated is set in the next cycle and input stops.
- R10: done, err_unknown_tag and err_truncated stay set until reset, and done is never set together with an error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of the input |
| in_ready | output | 1 | Block accepts the input byte |
| str_valid | output | 1 | Text character strobe |
| str_field | output | 2 | Field code of the character (0..3 for 'a'..'d') |
| str_byte | output | 8 | Text character |
| str_last | output | 1 | Final character of the field |
| pay_len | output | 32 | Declared payload length |
| pay_len_valid | output | 1 | pay_len has been captured |
| pay_valid | output | 1 | Payload byte present |
| pay_data | output | 8 | Payload byte |
| pay_ready | input | 1 | Downstream accepts payload |
| done | output | 1 | Payload fully forwarded |
| err_unknown_tag | output | 1 | An unrecognised tag was read |
| err_truncated | output | 1 | Input ended before the container did |

## Verification
A parse state that slips by one byte shows up at once. The next tag is read from a length or text byte, which either raises err_unknown_tag within a few cycles or places characters under the wrong field code on the capture strobe. A wrong remaining-byte count shows up at the end of a field or of the payload. The str_last marker appears on the wrong character, the payload log gains or loses bytes, or done rises a cycle early or late. Any of these can be seen at the ports in the cycle after the affected byte. Byte order in the length fields is checked with lengths whose two halves differ, so a swapped byte changes the byte count right away.

// File: rtl/bitfile_hdr_pkg.sv
package bitfile_hdr_pkg;
    localparam int LEN_W          = 32;
    localparam int SHORT_LEN_W    = 16;
    localparam int FID_W          = 2;
    localparam logic [7:0] TAG_TEXT_FIRST = 8'h61;
    localparam int TAG_TEXT_COUNT = 4;
    localparam logic [7:0] TAG_DATA       = 8'h65;

    typedef enum logic [3:0] {
        S_PRE_LEN,
        S_PRE_SKIP,
        S_HDR_WORD,
        S_TAG,
        S_STR_LEN,
        S_STR_BODY,
        S_PAY_LEN,
        S_PAY_BODY,
        S_DONE,
        S_ERR
    } walk_state_e;

    typedef struct packed {
        walk_state_e      st;
        logic [LEN_W-1:0] rem;
        logic [LEN_W-1:0] acc;
        logic [FID_W-1:0] fid;
        logic [LEN_W-1:0] plen;
        logic             plen_vld;
        logic             sv;
        logic [7:0]       sb;
        logic [FID_W-1:0] sf;
        logic             sl;
        logic             e_tag;
        logic             e_trunc;
    } walk_regs_t;
endpackage

// File: rtl/bitfile_tag_class.sv
module bitfile_tag_class
    import bitfile_hdr_pkg::*;
(
    input  logic [7:0]       tag_byte,
    output logic             is_text,
    output logic             is_data,
    output logic [FID_W-1:0] text_id
);
    logic [7:0] offset;

    always_comb begin
        offset  = tag_byte - TAG_TEXT_FIRST;
        is_text = (offset < 8'(TAG_TEXT_COUNT));
        is_data = (tag_byte == TAG_DATA);
        text_id = offset[FID_W-1:0];
    end
endmodule

// File: rtl/bitfile_hdr_walker.sv
module bitfile_hdr_walker
    import bitfile_hdr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             in_ready,
    output logic             str_valid,
    output logic [FID_W-1:0] str_field,
    output logic [7:0]       str_byte,
    output logic             str_last,
    output logic [LEN_W-1:0] pay_len,
    output logic             pay_len_valid,
    output logic             pay_valid,
    output logic [7:0]       pay_data,
    input  logic             pay_ready,
    output logic             done,
    output logic             err_unknown_tag,
    output logic             err_truncated
);
    walk_regs_t q, d;
    logic             take;
    logic [LEN_W-1:0] acc_n;
    logic [LEN_W-1:0] short_len;
    logic             tag_text, tag_data;
    logic [FID_W-1:0] tag_id;

    bitfile_tag_class u_tag (
        .tag_byte (in_data),
        .is_text  (tag_text),
        .is_data  (tag_data),
        .text_id  (tag_id)
    );

    always_comb begin
        case (q.st)
            S_DONE, S_ERR: in_ready = 1'b0;
            S_PAY_BODY:    in_ready = pay_ready;
            default:       in_ready = 1'b1;
        endcase
    end

    always_comb begin
        d         = q;
        d.sv      = 1'b0;
        d.sl      = 1'b0;
        take      = in_valid && in_ready;
        acc_n     = {q.acc[LEN_W-9:0], in_data};
        short_len = LEN_W'(acc_n[SHORT_LEN_W-1:0]);
        if (take) begin
            d.acc = acc_n;
            case (q.st)
                S_PRE_LEN: begin
                    if (q.rem == '0) begin
                        if (short_len == '0) begin
                            d.st  = S_HDR_WORD;
                            d.rem = LEN_W'(1);
                        end else begin
                            d.st  = S_PRE_SKIP;
                            d.rem = short_len - 1'b1;
                        end
                    end else begin
                        d.rem = q.rem - 1'b1;
                    end
                end
                S_PRE_SKIP: begin
                    if (q.rem == '0) begin
                        d.st  = S_HDR_WORD;
                        d.rem = LEN_W'(1);
                    end else begin
                        d.rem = q.rem - 1'b1;
                    end
                end
                S_HDR_WORD: begin
                    if (q.rem == '0) d.st = S_TAG;
                    else             d.rem = q.rem - 1'b1;
                end
                S_TAG: begin
                    if (tag_text) begin
                        d.st  = S_STR_LEN;
                        d.rem = LEN_W'(1);
                        d.fid = tag_id;
                    end else if (tag_data) begin
                        d.st  = S_PAY_LEN;
                        d.rem = LEN_W'(3);
                    end else begin
                        d.st    = S_ERR;
                        d.e_tag = 1'b1;
                    end
                end
                S_STR_LEN: begin
                    if (q.rem == '0) begin
                        if (short_len == '0) begin
                            d.st = S_TAG;
                        end else begin
                            d.st  = S_STR_BODY;
                            d.rem = short_len - 1'b1;
                        end
                    end else begin
                        d.rem = q.rem - 1'b1;
                    end
                end
                S_STR_BODY: begin
                    d.sv = 1'b1;
                    d.sb = in_data;
                    d.sf = q.fid;
                    d.sl = (q.rem == '0);
                    if (q.rem == '0) d.st = S_TAG;
                    else             d.rem = q.rem - 1'b1;
                end
                S_PAY_LEN: begin
                    if (q.rem == '0) begin
                        d.plen     = acc_n;
                        d.plen_vld = 1'b1;
                        if (acc_n == '0) begin
                            d.st = S_DONE;
                        end else begin
                            d.st  = S_PAY_BODY;
                            d.rem = acc_n - 1'b1;
                        end
                    end else begin
                        d.rem = q.rem - 1'b1;
                    end
                end
                S_PAY_BODY: begin
                    if (q.rem == '0) d.st = S_DONE;
                    else             d.rem = q.rem - 1'b1;
                end
                default: ;
            endcase
            if (in_last && d.st != S_DONE && d.st != S_ERR) begin
                d.st     = S_ERR;
                d.e_trunc = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: S_PRE_LEN, rem: LEN_W'(1), default: '0};
        end else begin
            q <= d;
        end
    end

    assign str_valid       = q.sv;
    assign str_field       = q.sf;
    assign str_byte        = q.sb;
    assign str_last        = q.sl;
    assign pay_len         = q.plen;
    assign pay_len_valid   = q.plen_vld;
    assign pay_valid       = (q.st == S_PAY_BODY) && in_valid;
    assign pay_data        = in_data;
    assign done            = (q.st == S_DONE);
    assign err_unknown_tag = q.e_tag;
    assign err_truncated   = q.e_trunc;

    p_str_after_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
        str_valid |-> $past(in_valid && in_ready));
    p_str_gap_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (str_valid && str_last) |=> !str_valid);
    p_len_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pay_len_valid |=> (pay_len_valid && $stable(pay_len)));
    p_streams_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(pay_valid && str_valid));
    p_done_after_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(in_valid && in_ready));
    p_flags_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err_unknown_tag || err_truncated) |=>
        (done || err_unknown_tag || err_truncated));
    p_done_no_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && (err_unknown_tag || err_truncated)));
endmodule

// File: tb/bitfile_hdr_walker_test.sv
module bitfile_hdr_walker_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        str_valid;
    logic [1:0]  str_field;
    logic [7:0]  str_byte;
    logic        str_last;
    logic [31:0] pay_len;
    logic        pay_len_valid;
    logic        pay_valid;
    logic [7:0]  pay_data;
    logic        pay_ready = 1'b1;
    logic        done;
    logic        err_unknown_tag;
    logic        err_truncated;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    bit stall_en = 1'b0;
    bit finished = 1'b0;

    logic [7:0]  stim[$];
    logic [10:0] str_log[$];
    logic [10:0] exp_str[$];
    logic [7:0]  pay_log[$];
    logic [7:0]  exp_pay[$];

    bitfile_hdr_walker uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .str_valid(str_valid),
        .str_field(str_field), .str_byte(str_byte), .str_last(str_last),
        .pay_len(pay_len), .pay_len_valid(pay_len_valid), .pay_valid(pay_valid),
        .pay_data(pay_data), .pay_ready(pay_ready), .done(done),
        .err_unknown_tag(err_unknown_tag), .err_truncated(err_truncated)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (rst_n) begin
            if (str_valid) str_log.push_back({str_field, str_last, str_byte});
            if (pay_valid && pay_ready) pay_log.push_back(pay_data);
        end
    end

    always @(posedge clk) begin
        #1;
        pay_ready <= stall_en ? ~pay_ready : 1'b1;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        in_valid = 1'b0;
        in_last  = 1'b0;
        stall_en = 1'b0;
        rst_n    = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        stim.delete(); str_log.delete(); exp_str.delete();
        pay_log.delete(); exp_pay.delete();
    endtask

    task automatic push16(int v);
        stim.push_back(8'((v >> 8) & 8'hFF));
        stim.push_back(8'(v & 8'hFF));
    endtask

    task automatic push32(int v);
        for (int k = 3; k >= 0; k--) stim.push_back(8'((v >> (8*k)) & 8'hFF));
    endtask

    task automatic push_text(logic [7:0] tag, string s);
        stim.push_back(tag);
        push16(s.len());
        for (int k = 0; k < s.len(); k++) begin
            stim.push_back(s[k]);
            exp_str.push_back({2'(tag - 8'h61), (k == s.len() - 1), s[k]});
        end
    endtask

    task automatic push_preamble(int n, int word2);
        push16(n);
        for (int k = 0; k < n; k++) stim.push_back(8'(8'h61 + k));
        push16(word2);
    endtask

    task automatic send_byte(logic [7:0] b, logic l);
        bit got;
        in_valid = 1'b1;
        in_data  = b;
        in_last  = l;
        do begin
            @(negedge clk);
            got = in_ready;
            @(posedge clk);
            #1;
        end while (!got);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic send_all(int trunc_at);
        for (int i = 0; i < stim.size(); i++) begin
            bit l;
            l = (i == stim.size() - 1) || (i == trunc_at);
            send_byte(stim[i], l);
            if (i == trunc_at) break;
        end
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic compare_logs(string req);
        chk(req, "text strobe count", str_log.size(), exp_str.size());
        for (int i = 0; i < exp_str.size() && i < str_log.size(); i++)
            if (str_log[i] !== exp_str[i]) begin
                chk(req, "text strobe entry", str_log[i], exp_str[i]);
                break;
            end
        chk(req, "payload byte count", pay_log.size(), exp_pay.size());
        for (int i = 0; i < exp_pay.size() && i < pay_log.size(); i++)
            if (pay_log[i] !== exp_pay[i]) begin
                chk(req, "payload byte", pay_log[i], exp_pay[i]);
                break;
            end
    endtask

    task automatic t_reset_state();
        do_reset();
        @(negedge clk);
        chk("R1", "in_ready", in_ready, 1);
        chk("R1", "flags", {done, err_unknown_tag, err_truncated, pay_len_valid}, 0);
        chk("R1", "strobes", {str_valid, pay_valid}, 0);
    endtask

    task automatic t_full_container();
        do_reset();
        push_preamble(3, 16'hFFFF);
        push_text(8'h61, "ab");
        push_text(8'h62, "xc7");
        push_text(8'h63, "");
        push_text(8'h64, "Z");
        stim.push_back(8'h65);
        push32(5);
        for (int k = 0; k < 5; k++) begin
            stim.push_back(8'(8'hC0 + k));
            exp_pay.push_back(8'(8'hC0 + k));
        end
        send_all(-1);
        compare_logs("R2 R3 R4 R6");
        chk("R5", "pay_len", pay_len, 5);
        chk("R5", "pay_len_valid", pay_len_valid, 1);
        chk("R7", "done", done, 1);
        chk("R7", "in_ready after done", in_ready, 0);
        chk("R10", "no error with done", {err_unknown_tag, err_truncated}, 0);
        repeat (5) @(posedge clk);
        #1;
        chk("R10", "done sticky", done, 1);
        chk("R5", "pay_len held", pay_len, 5);
    endtask

    task automatic t_stalled_payload();
        do_reset();
        push_preamble(0, 16'h1234);
        push_text(8'h64, "q");
        push_text(8'h61, "hi");
        stim.push_back(8'h65);
        push32(300);
        for (int k = 0; k < 300; k++) begin
            stim.push_back(8'((k * 7) & 8'hFF));
            exp_pay.push_back(8'((k * 7) & 8'hFF));
        end
        stall_en = 1'b1;
        send_all(-1);
        stall_en = 1'b0;
        compare_logs("R6 R4");
        chk("R5", "pay_len big-endian", pay_len, 300);
        chk("R7", "done after stalls", done, 1);
    endtask

    task automatic t_zero_payload();
        do_reset();
        push_preamble(1, 0);
        stim.push_back(8'h65);
        push32(0);
        for (int i = 0; i < stim.size(); i++) send_byte(stim[i], i == stim.size() - 1);
        chk("R7", "done next cycle on zero length", done, 1);
        chk("R9", "no truncation at true end", err_truncated, 0);
        chk("R5", "pay_len zero", {pay_len_valid, pay_len}, {1'b1, 32'h0});
        compare_logs("R7");
    endtask

    task automatic t_unknown_tag();
        do_reset();
        push_preamble(2, 16'h0003);
        push_text(8'h61, "q");
        stim.push_back(8'h66);
        send_all(-1);
        chk("R8", "err_unknown_tag", err_unknown_tag, 1);
        chk("R8", "truncation masked", err_truncated, 0);
        chk("R8", "in_ready stopped", in_ready, 0);
        chk("R10", "done clear on error", done, 0);
        compare_logs("R8");
    endtask

    task automatic t_trunc_text();
        do_reset();
        push_preamble(0, 0);
        stim.push_back(8'h62);
        push16(3);
        stim.push_back(8'h78);
        stim.push_back(8'h79);
        exp_str.push_back({2'd1, 1'b0, 8'h78});
        exp_str.push_back({2'd1, 1'b0, 8'h79});
        send_all(-1);
        chk("R9", "err_truncated in text", err_truncated, 1);
        chk("R9", "in_ready stopped", in_ready, 0);
        compare_logs("R9");
    endtask

    task automatic t_trunc_payload();
        do_reset();
        push_preamble(0, 0);
        stim.push_back(8'h65);
        push32(4);
        for (int k = 0; k < 4; k++) stim.push_back(8'(8'h10 + k));
        exp_pay.push_back(8'h10);
        exp_pay.push_back(8'h11);
        send_all(stim.size() - 3);
        chk("R9", "err_truncated in payload", err_truncated, 1);
        chk("R10", "done clear", done, 0);
        compare_logs("R9");
        repeat (4) @(posedge clk);
        #1;
        chk("R10", "error sticky", err_truncated, 1);
    endtask

    initial begin
        t_reset_state();
        t_full_container();
        t_stalled_payload();
        t_zero_payload();
        t_unknown_tag();
        t_trunc_text();
        t_trunc_payload();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule